// File: doc/BRIEF.md
# SPI Master with Command-Bit Framing

This block is an SPI master that shifts characters out on a serial data line and captures the bits returned on the input line, both in step with a clock it generates itself. A single-entry transmit buffer sits in front of the shift register. Software writes a byte into the buffer, and the block moves it into the shift register as soon as the line is free. A byte written while a frame is in flight waits in the buffer and starts the moment the current frame ends. The active-low chip select stays asserted across such back-to-back frames.

Characters are either 8 bits long or 9 bits long. In 9-bit mode a command bit taken from the configuration register goes in front of the data byte. Display controllers use this extra bit to tell a command from pixel or parameter data. Clock polarity and clock phase are both selectable. A transmit-buffer-empty flag tells software when the next byte may be written. Writing 1 to the flag clears it, and the flag drives an interrupt request when the interrupt is enabled.

The serial clock runs at the system clock divided by the even parameter `CLK_DIV`. Software reaches the block through a small register port with a 2-bit address and a combinational read path.

Top module: `spi_cmd_master`

## Requirements
- R1: After reset the status register (address 2) reads 0x01, meaning the buffer is empty and the block is not busy. The configuration register (address 1) and `rxData` read 0, `csN` is high, and `sclk` and `mosi` are low.
- R2: A write to address 0 stores the byte in the buffer and clears the empty flag (status bit 0) at that clock edge. If no frame is running, the byte moves into the shift register on the next edge. At that edge the empty flag sets again, busy (status bit 1) rises and `csN` falls.
- R3: Writing the status register with data bit 0 set clears the empty flag, and writing it with bit 0 clear leaves the flag unchanged. When the same edge also moves a byte into the shift register, the flag sets. A write to address 0 in that same edge clears it again.
- R4: `irq` is high exactly while the empty flag is 1 and the interrupt enable (configuration bit 4) is 1.
- R5: With configuration bit 0 at 0, a frame is 8 bits, sent most significant bit first. The command bit (configuration bit 1) has no effect on `mosi`.
- R6: With configuration bit 0 at 1, a frame is 9 bits: the command bit (configuration bit 1) first, then the data byte MSB first. The frame length is taken when the byte enters the shift register.
- R7: `sclk` rests at the level of configuration bit 2 (0 means idle low, 1 means idle high). During a frame it toggles every `CLK_DIV/2` system clocks, the first toggle coming `CLK_DIV/2` clocks after the load, with two toggles per bit.
- R8: With configuration bit 3 at 0, the first bit is on `mosi` from the load. Each following bit changes on a trailing edge, and `miso` is sampled on leading edges. With bit 3 at 1, bits after the first change on leading edges and `miso` is sampled on trailing edges.
- R9: At the final clock edge of a frame, `rxData` takes the last 8 sampled `miso` bits, the first received bit being the MSB. `rxValid` pulses high for one cycle. In 9-bit mode the sample taken in the command-bit slot is discarded.
- R10: Busy stays high and `csN` low from the load until the final clock edge of the frame. If the buffer holds a byte at that edge, the byte is loaded at the same edge, and busy and `csN` stay active without a gap.
- R11: Reads are combinational. Address 0 returns `rxData`, address 1 returns configuration bits 4..0 with bits 7..5 reading 0, address 2 returns {6'b0, busy, empty flag}, and address 3 returns 0. Between frames `mosi` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Active-low chip select |
| irq | output | 1 | Transmit-buffer-empty interrupt request |
| rxData | output | DATA_W | Last received byte |
| rxValid | output | 1 | One-cycle pulse when rxData updates |

## Verification
The empty flag clears at the edge that samples a data write, and the load follows one edge later when the line is idle. The first `sclk` toggle comes `CLK_DIV/2` clocks after the load, and `rxData`/`rxValid` change at the frame's final edge, `2*n*CLK_DIV/2` clocks after the load for an n-bit frame. The bench has a behavioural model that advances by one clock edge per cycle and counts clocks since the load to derive the `sclk` level and the index of the bit on `mosi`. All outputs and the selected read register are compared against this model at every falling edge, half a period after the edge on which the design changes them. `miso` is looped back from `mosi`, optionally inverted, so the received byte is known in advance.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;
  localparam int CFG_W = 5;

  // Configuration register; first field is the most significant bit (bit 4).
  typedef struct packed {
    logic irqEn;   // bit 4
    logic cpha;    // bit 3
    logic cpol;    // bit 2
    logic cmdBit;  // bit 1
    logic len9;    // bit 0
  } cfg_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic bufWrite;  // store write data in the transmit buffer
    logic load;      // move buffer into shift register
    logic shift;     // advance to next outgoing bit
    logic sample;    // capture miso
    logic finish;    // final clock edge of the frame
  } dp_ctl_t;

endpackage

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] regRdData,
  output logic              sclk,
  output logic              csN,
  output logic              irq,
  output logic              cmdBit,
  output logic              len9,
  output dp_ctl_t           ctl
);

  localparam int HALF      = CLK_DIV / 2;
  localparam int DIV_W     = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int MAX_EDGES = 2 * (DATA_W + 1);
  localparam int EDGE_W    = $clog2(MAX_EDGES);

  cfg_t              cfgQ;
  logic              flagQ;
  logic              bufFull;
  logic              busyQ;
  logic              csNQ;
  logic              sclkInt;
  logic              len9Lat;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] lastEdge;
  logic              tick;
  logic              frameEnd;
  logic              load;
  logic              leading;
  logic              dataWr;
  logic              cfgWr;
  logic              statWr;

  assign dataWr = regWrEn && (regAddr == ADDR_DATA);
  assign cfgWr  = regWrEn && (regAddr == ADDR_CFG);
  assign statWr = regWrEn && (regAddr == ADDR_STAT);

  // Half-period divider; a divide-by-two clock needs no counter.
  generate
    if (HALF > 1) begin : g_div
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                        divCnt <= '0;
        else if (!busyQ || load || tick)  divCnt <= '0;
        else                              divCnt <= divCnt + DIV_W'(1);
      end
      assign tick = busyQ && (divCnt == DIV_W'(HALF - 1));
    end else begin : g_nodiv
      assign tick = busyQ;
    end
  endgenerate

  assign lastEdge = len9Lat ? EDGE_W'(2 * (DATA_W + 1) - 1) : EDGE_W'(2 * DATA_W - 1);
  assign frameEnd = tick && (edgeCnt == lastEdge);
  assign load     = bufFull && (!busyQ || frameEnd);
  assign leading  = !edgeCnt[0];

  always_comb begin
    ctl          = '0;
    ctl.bufWrite = dataWr;
    ctl.load     = load;
    ctl.finish   = frameEnd;
    ctl.sample   = tick && (cfgQ.cpha ? !leading : leading);
    ctl.shift    = tick && !frameEnd &&
                   (cfgQ.cpha ? (leading && (edgeCnt != '0)) : !leading);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= '0;
      flagQ   <= 1'b1;
      bufFull <= 1'b0;
      busyQ   <= 1'b0;
      csNQ    <= 1'b1;
      edgeCnt <= '0;
      sclkInt <= 1'b0;
      len9Lat <= 1'b0;
    end else begin
      if (cfgWr) cfgQ <= cfg_t'(cfgWrData);

      if (dataWr)                        flagQ <= 1'b0;
      else if (load)                     flagQ <= 1'b1;
      else if (statWr && cfgWrData[0])   flagQ <= 1'b0;

      if (dataWr)    bufFull <= 1'b1;
      else if (load) bufFull <= 1'b0;

      if (load) begin
        busyQ   <= 1'b1;
        csNQ    <= 1'b0;
        edgeCnt <= '0;
        sclkInt <= 1'b0;
        len9Lat <= cfgQ.len9;
      end else if (frameEnd) begin
        busyQ   <= 1'b0;
        csNQ    <= 1'b1;
        edgeCnt <= '0;
        sclkInt <= 1'b0;
      end else if (tick) begin
        edgeCnt <= edgeCnt + EDGE_W'(1);
        sclkInt <= ~sclkInt;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_DATA: regRdData = rxData;
      ADDR_CFG:  regRdData[CFG_W-1:0] = cfgQ;
      ADDR_STAT: regRdData[1:0] = {busyQ, flagQ};
      default:   regRdData = '0;
    endcase
  end

  assign sclk   = sclkInt ^ cfgQ.cpol;
  assign csN    = csNQ;
  assign irq    = flagQ & cfgQ.irqEn;
  assign cmdBit = cfgQ.cmdBit;
  assign len9   = cfgQ.len9;

  assert_cs_tracks_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    busyQ == !csNQ);

  assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> !sclkInt);

  assert_flag_set_on_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (load && !dataWr) |=> flagQ);

  assert_w0_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && !cfgWrData[0] && !dataWr && flagQ) |=> flagQ);

  assert_edge_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (edgeCnt <= lastEdge));

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_CFG) |-> (regRdData[DATA_W-1:CFG_W] == '0));

endmodule

// File: rtl/spi_cmd_dp.sv
module spi_cmd_dp
  import spi_cmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic              cmdBit,
  input  logic              len9,
  input  logic [DATA_W-1:0] wrData,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid
);

  localparam int FRAME_W = DATA_W + 1;

  logic [DATA_W-1:0]  bufQ;
  logic [FRAME_W-1:0] shiftQ;
  logic [DATA_W-1:0]  rxShift;
  logic [DATA_W-1:0]  rxNext;
  logic [DATA_W-1:0]  rxDataQ;
  logic               rxValidQ;

  assign rxNext = ctl.sample ? {rxShift[DATA_W-2:0], miso} : rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufQ     <= '0;
      shiftQ   <= '0;
      rxShift  <= '0;
      rxDataQ  <= '0;
      rxValidQ <= 1'b0;
    end else begin
      if (ctl.bufWrite) bufQ <= wrData;

      if (ctl.load)        shiftQ <= len9 ? {cmdBit, bufQ} : {bufQ, 1'b0};
      else if (ctl.finish) shiftQ <= '0;
      else if (ctl.shift)  shiftQ <= {shiftQ[FRAME_W-2:0], 1'b0};

      if (ctl.sample) rxShift <= rxNext;
      if (ctl.finish) rxDataQ <= rxNext;
      rxValidQ <= ctl.finish;
    end
  end

  assign mosi    = shiftQ[FRAME_W-1];
  assign rxData  = rxDataQ;
  assign rxValid = rxValidQ;

  assert_rx_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxValidQ |=> !rxValidQ);

endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
  import spi_cmd_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              csN,
  output logic              irq,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid
);

  dp_ctl_t ctl;
  logic    cmdBit;
  logic    len9;

  spi_cmd_ctrl #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .cfgWrData (regWrData[CFG_W-1:0]),
    .rxData    (rxData),
    .regRdData (regRdData),
    .sclk      (sclk),
    .csN       (csN),
    .irq       (irq),
    .cmdBit    (cmdBit),
    .len9      (len9),
    .ctl       (ctl)
  );

  spi_cmd_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .cmdBit  (cmdBit),
    .len9    (len9),
    .wrData  (regWrData),
    .miso    (miso),
    .mosi    (mosi),
    .rxData  (rxData),
    .rxValid (rxValid)
  );

endmodule

// File: tb/spi_cmd_master_bench.sv
module spi_cmd_master_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW   = 8;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic          clk = 1'b0;
  logic          rstN;
  logic          regWrEn;
  logic [1:0]    regAddr;
  logic [DW-1:0] regWrData;
  logic [DW-1:0] regRdData;
  logic          sclk, mosi, miso, csN, irq, rxValid;
  logic [DW-1:0] rxData;
  logic          missInv;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign miso = mosi ^ missInv;

  spi_cmd_master #(.DATA_W(DW), .CLK_DIV(DIV)) u_spi_cmd_master (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sclk(sclk), .mosi(mosi),
    .miso(miso), .csN(csN), .irq(irq), .rxData(rxData), .rxValid(rxValid)
  );

  // Behavioural reference model
  logic       mBusy, mPend, mFlag, mRxValid, mLen9, mCmd;
  logic [7:0] mPendByte, mCur, mRx;
  logic [4:0] mCfg;
  int         mT;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 0; mPend = 0; mFlag = 1; mRxValid = 0; mLen9 = 0; mCmd = 0;
      mPendByte = 0; mCur = 0; mRx = 0; mCfg = 0; mT = 0;
    end else begin
      logic endNow, loadNow;
      int nBits;
      nBits = mLen9 ? 9 : 8;
      mRxValid = 0;
      endNow = mBusy && (mT + 1 == 2 * nBits * HALF);
      if (mBusy) mT = mT + 1;
      if (endNow) begin
        mRx = mCur ^ {8{missInv}};
        mRxValid = 1;
        mBusy = 0;
      end
      loadNow = mPend && !mBusy;
      if (loadNow) begin
        mBusy = 1; mT = 0; mLen9 = mCfg[0]; mCmd = mCfg[1];
        mCur = mPendByte; mPend = 0; mFlag = 1;
      end
      if (regWrEn && regAddr == 2'd0) begin
        mPendByte = regWrData; mPend = 1; mFlag = 0;
      end else if (regWrEn && regAddr == 2'd2 && regWrData[0] && !loadNow) begin
        mFlag = 0;
      end
      if (regWrEn && regAddr == 2'd1) mCfg = regWrData[4:0];
    end
  end

  function automatic logic frameBit(input logic len9, input logic cmd,
                                    input logic [7:0] d, input int i);
    if (len9) return (i == 0) ? cmd : d[8 - i];
    return d[7 - i];
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int k, idx;
    logic eSclk, eMosi;
    logic [7:0] eRd;
    vectors++;
    k = mT / HALF;
    if (mCfg[3]) idx = (k == 0) ? 0 : (k - 1) / 2;
    else         idx = k / 2;
    eSclk = mBusy ? ((k % 2 == 1) ^ mCfg[2]) : mCfg[2];
    eMosi = mBusy ? frameBit(mLen9, mCmd, mCur, idx) : 1'b0;
    case (regAddr)
      2'd0:    eRd = mRx;
      2'd1:    eRd = {3'b000, mCfg};
      2'd2:    eRd = {6'b0, mBusy, mFlag};
      default: eRd = 8'h00;
    endcase
    chk("R2 R10 csN", {7'b0, csN}, {7'b0, !mBusy});
    chk("R7 sclk", {7'b0, sclk}, {7'b0, eSclk});
    chk(mLen9 ? "R6 R8 mosi" : "R5 R8 mosi", {7'b0, mosi}, {7'b0, eMosi});
    chk("R4 irq", {7'b0, irq}, {7'b0, mFlag & mCfg[4]});
    chk("R9 rxValid", {7'b0, rxValid}, {7'b0, mRxValid});
    chk("R9 rxData", rxData, mRx);
    chk("R11 R3 readback", regRdData, eRd);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    cyc();
    regWrEn = 0; regWrData = 0;
  endtask

  task automatic idleCyc();
    regAddr = regAddr + 2'd1;
    cyc();
  endtask

  task automatic waitIdle();
    while (mBusy || mPend) idleCyc();
    idleCyc();
  endtask

  task automatic direct(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    chk(tag, act, exp);
  endtask

  task automatic sendFrame(input logic [7:0] cfg, input logic [7:0] b);
    wr(2'd1, cfg);
    wr(2'd0, b);
    waitIdle();
  endtask

  initial begin
    rstN = 0; regWrEn = 0; regAddr = 2'd2; regWrData = 0; missInv = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    cyc();
    // R1 reset state
    direct("R1 status after reset", regRdData, 8'h01);
    direct("R1 csN after reset", {7'b0, csN}, 8'h01);
    direct("R1 sclk after reset", {7'b0, sclk}, 8'h00);
    direct("R1 rxData after reset", rxData, 8'h00);
    regAddr = 2'd1; #1;
    direct("R1 config after reset", regRdData, 8'h00);

    // R5: 8-bit, command bit set but ignored
    wr(2'd1, 8'h02);
    wr(2'd0, 8'hA5);
    regAddr = 2'd2; #1;
    direct("R2 flag cleared by data write", regRdData, 8'h00);
    cyc();
    direct("R2 load sets flag and busy", regRdData, 8'h03);
    direct("R2 csN low after load", {7'b0, csN}, 8'h00);
    waitIdle();
    regAddr = 2'd0; #1;
    direct("R9 loopback byte", rxData, 8'hA5);

    // R4 / R3: interrupt gating and write-one-to-clear
    wr(2'd1, 8'h10);
    direct("R4 irq with flag and enable", {7'b0, irq}, 8'h01);
    wr(2'd2, 8'h00);
    direct("R3 write 0 keeps flag", {7'b0, irq}, 8'h01);
    wr(2'd2, 8'h01);
    direct("R3 write 1 clears flag", {7'b0, irq}, 8'h00);
    wr(2'd1, 8'h00);
    direct("R4 irq off without enable", {7'b0, irq}, 8'h00);

    // R6: 9-bit frames, command 1 then 0
    sendFrame(8'h03, 8'h3C);
    sendFrame(8'h01, 8'hC3);
    // R7 / R8: polarity and phase combinations
    sendFrame(8'h04, 8'h96);
    sendFrame(8'h08, 8'h5A);
    sendFrame(8'h0D, 8'h81);
    sendFrame(8'h0A, 8'h7E);
    // R9: inverted return data
    missInv = 1;
    sendFrame(8'h0C, 8'h33);
    regAddr = 2'd0; #1;
    direct("R9 inverted return byte", rxData, 8'hCC);
    missInv = 0;
    sendFrame(8'hE0, 8'h44);
    regAddr = 2'd1; #1;
    direct("R11 reserved config bits read 0", regRdData, 8'h00);

    // R10: back-to-back frames with chip select held
    wr(2'd1, 8'h11);
    wr(2'd0, 8'h11);
    repeat (5) idleCyc();
    wr(2'd0, 8'h22);
    while (!mFlag) idleCyc();
    wr(2'd0, 8'h33);
    while (!mFlag) idleCyc();
    idleCyc();
    direct("R10 csN held between frames", {7'b0, csN}, 8'h00);
    waitIdle();
    regAddr = 2'd0; #1;
    direct("R9 last back-to-back byte", rxData, 8'h33);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule